// File: doc/BRIEF.md
# Duty-Cycled Receive Power Sequencer

This block saves receiver power by running the radio in bursts. A prescaler divides the system clock by a programmable integer to make a slow tick, nominally 100 kHz. On that tick the block times three periods in turn. The first is an off period with the RF sections unpowered. The second is a host-wake window, during which the block pulls the shared data line low to wake the host. The third is a settle period, during which RF power is on while the line is still held low.

The data line is wired-AND with an internal pull-up. The host answers the wake signal by pulling the line low itself. When the block lets go of the line, it reads the level. If the line is still low, the host is present, and the block enables the data outputs for as long as the host keeps the line low. When the host releases the line, a new off period starts. If the line reads high, the host did not answer, so the block removes RF power and starts a new off period.

Clearing the mode enable returns the block to idle, where the receiver runs continuously. The divisor and the three period counts are captured each time an off period begins, so a write never changes a period that is already running.

States: IDLE (continuous receive), ARM (waits for chip select and the data line to be high), OFF, WAKE, SETTLE, CHECK (one cycle, line released and sampled), ACTIVE. Transitions:
- IDLE→ARM when the mode is enabled.
- ARM→OFF when chip select and the line are both high.
- OFF→WAKE, WAKE→SETTLE and SETTLE→CHECK when each period ends.
- CHECK→ACTIVE when the line is low.
- CHECK→OFF when the line is high.
- ACTIVE→OFF when the line goes high.
- Any state→IDLE when the mode is disabled.

Top module: `rxduty_seq`

## Requirements
- R1: While drx_en is low (and after reset), rf_power_en=1, data_out_en=1 and dio_pull_low=0.
- R2: With drx_en high, the block waits with all three outputs low until cs and dio_in are both sampled high on the same edge. If either one is low, no cycle starts.
- R3: An off period lasts max(off_count,1)*max(xtal_div,1) clock cycles with all three outputs low.
- R4: The wake window lasts max(host_count,1)*max(xtal_div,1) cycles with dio_pull_low=1 and rf_power_en=0.
- R5: The settle period lasts max(settle_count,1)*max(xtal_div,1) cycles with dio_pull_low=1 and rf_power_en=1.
- R6: After the settle period comes one cycle with dio_pull_low=0, rf_power_en=1 and data_out_en=0. If dio_in is high in that cycle, the block goes to a new off period with RF power removed.
- R7: If dio_in is low in that cycle, rf_power_en and data_out_en are both 1 until dio_in is sampled high. The next cycle then begins a new off period.
- R8: Clearing drx_en in any state gives the R1 outputs from the next cycle.
- R9: xtal_div and the three counts are captured only when an off period begins. Changes made during a cycle take effect at the next off period.
- R10: data_out_en is never high while rf_power_en is low, and dio_pull_low is never high together with data_out_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drx_en | input | 1 | Duty-cycled receive mode enable |
| xtal_div | input | 8 | Clock divisor for the slow tick (0 acts as 1) |
| off_count | input | 16 | Off period in ticks (0 acts as 1) |
| host_count | input | 16 | Host-wake window in ticks (0 acts as 1) |
| settle_count | input | 16 | Receiver settle period in ticks (0 acts as 1) |
| cs | input | 1 | Chip select from the host |
| dio_in | input | 1 | Level of the shared data line |
| dio_pull_low | output | 1 | Drive the shared data line low |
| rf_power_en | output | 1 | Power enable for the RF sections |
| data_out_en | output | 1 | Enable for the received-data outputs |

## Verification
The power cycle is run with random divisors and period counts, including zero values that must act as one. Each new setting is written during the previous cycle, so the measured lengths show whether values are captured at the start of the off period or read live. Two host behaviours are mixed: a host that answers during the wake window and holds the line for a random time, and a host that never answers. These separate the CHECK decision into its two branches, ACTIVE and power-down. Directed cases hold off the start with chip select low or with the line low, and clear the enable in the middle of a wake window.

// File: rtl/rxduty_pkg.sv
package rxduty_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_OFF,
        ST_WAKE,
        ST_SETTLE,
        ST_CHECK,
        ST_ACTIVE
    } seq_state_t;
endpackage

// File: rtl/rxduty_tick.sv
module rxduty_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = (div == '0) ? '0 : div - 1'b1;
        tick = run && (pcnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (restart)
            pcnt <= '0;
        else if (run)
            pcnt <= tick ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/rxduty_timer.sv
module rxduty_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = (target == '0) ? '0 : target - 1'b1;
        done = tick && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rxduty_cfg.sv
module rxduty_cfg #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic [CNT_W-1:0] off_in,
    input  logic [CNT_W-1:0] host_in,
    input  logic [CNT_W-1:0] settle_in,
    output logic [DIV_W-1:0] div_q,
    output logic [CNT_W-1:0] off_q,
    output logic [CNT_W-1:0] host_q,
    output logic [CNT_W-1:0] settle_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            off_q    <= '0;
            host_q   <= '0;
            settle_q <= '0;
        end else if (load) begin
            div_q    <= div_in;
            off_q    <= off_in;
            host_q   <= host_in;
            settle_q <= settle_in;
        end
    end
endmodule

// File: rtl/rxduty_fsm.sv
module rxduty_fsm
    import rxduty_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drx_en,
    input  logic       cs,
    input  logic       dio_in,
    input  logic       period_done,
    output seq_state_t state,
    output logic       load_cfg,
    output logic       state_change,
    output logic       timing,
    output logic       pull_low,
    output logic       rf_on,
    output logic       dout_on
);
    seq_state_t state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (drx_en) state_n = ST_ARM;
            ST_ARM:    if (cs && dio_in) state_n = ST_OFF;
            ST_OFF:    if (period_done) state_n = ST_WAKE;
            ST_WAKE:   if (period_done) state_n = ST_SETTLE;
            ST_SETTLE: if (period_done) state_n = ST_CHECK;
            ST_CHECK:  state_n = dio_in ? ST_OFF : ST_ACTIVE;
            ST_ACTIVE: if (dio_in) state_n = ST_OFF;
            default:   state_n = ST_IDLE;
        endcase
        if (!drx_en)
            state_n = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    always_comb begin
        load_cfg     = (state_n == ST_OFF) && (state != ST_OFF);
        state_change = (state_n != state);
        timing       = 1'b0;
        pull_low     = 1'b0;
        rf_on        = 1'b0;
        dout_on      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                rf_on   = 1'b1;
                dout_on = 1'b1;
            end
            ST_ARM: ;
            ST_OFF:  timing = 1'b1;
            ST_WAKE: begin
                timing   = 1'b1;
                pull_low = 1'b1;
            end
            ST_SETTLE: begin
                timing   = 1'b1;
                pull_low = 1'b1;
                rf_on    = 1'b1;
            end
            ST_CHECK: rf_on = 1'b1;
            ST_ACTIVE: begin
                rf_on   = 1'b1;
                dout_on = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxduty_seq.sv
module rxduty_seq
    import rxduty_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drx_en,
    input  logic [DIV_W-1:0] xtal_div,
    input  logic [CNT_W-1:0] off_count,
    input  logic [CNT_W-1:0] host_count,
    input  logic [CNT_W-1:0] settle_count,
    input  logic             cs,
    input  logic             dio_in,
    output logic             dio_pull_low,
    output logic             rf_power_en,
    output logic             data_out_en
);
    seq_state_t       state;
    logic             load_cfg;
    logic             state_change;
    logic             timing;
    logic             tick;
    logic             period_done;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] off_q;
    logic [CNT_W-1:0] host_q;
    logic [CNT_W-1:0] settle_q;
    logic [CNT_W-1:0] target;

    rxduty_cfg #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cfg),
        .div_in   (xtal_div),
        .off_in   (off_count),
        .host_in  (host_count),
        .settle_in(settle_count),
        .div_q    (div_q),
        .off_q    (off_q),
        .host_q   (host_q),
        .settle_q (settle_q)
    );

    rxduty_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(load_cfg),
        .run    (timing),
        .div    (div_q),
        .tick   (tick)
    );

    always_comb begin
        unique case (state)
            ST_WAKE:   target = host_q;
            ST_SETTLE: target = settle_q;
            default:   target = off_q;
        endcase
    end

    rxduty_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_change),
        .tick  (tick),
        .target(target),
        .done  (period_done)
    );

    rxduty_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .drx_en      (drx_en),
        .cs          (cs),
        .dio_in      (dio_in),
        .period_done (period_done),
        .state       (state),
        .load_cfg    (load_cfg),
        .state_change(state_change),
        .timing      (timing),
        .pull_low    (dio_pull_low),
        .rf_on       (rf_power_en),
        .dout_on     (data_out_en)
    );
endmodule

// File: rtl/rxduty_seq_chk.sv
module rxduty_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic drx_en,
    input logic dio_in,
    input logic dio_pull_low,
    input logic rf_power_en,
    input logic data_out_en
);
    p_dout_needs_rf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_out_en |-> rf_power_en);

    p_no_pull_with_dout_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dio_pull_low |-> !data_out_en);

    p_idle_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !drx_en |=> (rf_power_en && data_out_en && !dio_pull_low));

    p_release_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drx_en && data_out_en && dio_in) |=> (!rf_power_en && !data_out_en));

    p_rf_rise_context_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_power_en) |-> (dio_pull_low || data_out_en));
endmodule

bind rxduty_seq rxduty_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drx_en      (drx_en),
    .dio_in      (dio_in),
    .dio_pull_low(dio_pull_low),
    .rf_power_en (rf_power_en),
    .data_out_en (data_out_en)
);

// File: tb/sim_rxduty_seq.sv
`timescale 1ns/1ps
module sim_rxduty_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drx_en = 1'b0;
    logic [7:0]  xtal_div = 8'd2;
    logic [15:0] off_count = 16'd3;
    logic [15:0] host_count = 16'd2;
    logic [15:0] settle_count = 16'd2;
    logic        cs = 1'b0;
    logic        host_low = 1'b0;
    logic        dio_in;
    logic        dio_pull_low;
    logic        rf_power_en;
    logic        data_out_en;

    int checks = 0;
    int fails = 0;
    bit done_flag = 1'b0;
    int cur_div, cur_off, cur_host, cur_settle;

    always #2 clk = ~clk;

    assign dio_in = ~(dio_pull_low | host_low);

    rxduty_seq u0 (
        .clk(clk), .rst_n(rst_n), .drx_en(drx_en), .xtal_div(xtal_div),
        .off_count(off_count), .host_count(host_count), .settle_count(settle_count),
        .cs(cs), .dio_in(dio_in), .dio_pull_low(dio_pull_low),
        .rf_power_en(rf_power_en), .data_out_en(data_out_en)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int plen(input int cnt, input int div);
        return eff(cnt) * eff(div);
    endfunction

    function automatic int pat(input logic p, input logic r, input logic d);
        return {p, r, d};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int exp);
        chk(req, pat(dio_pull_low, rf_power_en, data_out_en), exp);
    endtask

    // Entered at the negedge showing the first off-period cycle.
    task automatic round(input bit respond, input int hold,
                         input int n_div, input int n_off, input int n_host, input int n_set);
        int n;
        xtal_div = 8'(n_div);
        off_count = 16'(n_off);
        host_count = 16'(n_host);
        settle_count = 16'(n_set);
        n = 0;
        while (!dio_pull_low && !rf_power_en && !data_out_en) begin
            n++;
            @(negedge clk);
        end
        chk("R3 off length (R9 captured values)", n, plen(cur_off, cur_div));
        n = 0;
        while (dio_pull_low && !rf_power_en) begin
            if (respond) host_low = 1'b1;
            n++;
            @(negedge clk);
        end
        chk("R4 wake length", n, plen(cur_host, cur_div));
        n = 0;
        while (dio_pull_low && rf_power_en) begin
            n++;
            @(negedge clk);
        end
        chk("R5 settle length", n, plen(cur_settle, cur_div));
        chk_out("R6 check cycle", pat(1'b0, 1'b1, 1'b0));
        @(negedge clk);
        if (respond) begin
            chk_out("R7 active", pat(1'b0, 1'b1, 1'b1));
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk_out("R7 active held", pat(1'b0, 1'b1, 1'b1));
            end
            host_low = 1'b0;
            @(negedge clk);
            chk_out("R7 release restarts off", pat(1'b0, 1'b0, 1'b0));
        end else begin
            chk_out("R6 no answer powers down", pat(1'b0, 1'b0, 1'b0));
        end
        cur_div = n_div; cur_off = n_off; cur_host = n_host; cur_settle = n_set;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5a17;
        void'($urandom(seed));
        cur_div = 2; cur_off = 3; cur_host = 2; cur_settle = 2;
        repeat (3) @(negedge clk);
        chk_out("R1 reset idle", pat(1'b0, 1'b1, 1'b1));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_out("R1 idle while disabled", pat(1'b0, 1'b1, 1'b1));
        drx_en = 1'b1;
        @(negedge clk);
        chk_out("R2 armed", pat(1'b0, 1'b0, 1'b0));
        repeat (5) @(negedge clk);
        chk_out("R2 cs low holds start", pat(1'b0, 1'b0, 1'b0));
        cs = 1'b1;
        host_low = 1'b1;
        repeat (6) @(negedge clk);
        chk_out("R2 line low holds start", pat(1'b0, 1'b0, 1'b0));
        host_low = 1'b0;
        @(negedge clk);
        // directed: answer, then zero divisor/counts, then no answer
        round(1'b1, 3, 0, 0, 0, 0);
        round(1'b1, 0, 3, 1, 2, 1);
        round(1'b0, 0, 1, 4, 1, 3);
        round(1'b0, 0, 2, 2, 2, 2);
        for (int k = 0; k < 16; k++) begin
            round(1'($urandom_range(0, 3) != 0), $urandom_range(0, 6),
                  $urandom_range(0, 5), $urandom_range(0, 4),
                  $urandom_range(0, 4), $urandom_range(0, 4));
        end
        // disable during wake window
        while (!dio_pull_low) @(negedge clk);
        drx_en = 1'b0;
        @(negedge clk);
        chk_out("R8 disable returns to idle", pat(1'b0, 1'b1, 1'b1));
        repeat (4) @(negedge clk);
        chk_out("R1 idle after disable", pat(1'b0, 1'b1, 1'b1));
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule